// File: doc/BRIEF.md
# Descriptor-Chain DMA Fetch Controller

This block walks a linked list of descriptors held in word-addressed memory, one descriptor per frame. For each descriptor it hands a buffer pointer and a length to a frame-transfer engine. When the engine reports completion, the block writes the returned status into the descriptor and clears the ownership bit, which gives the descriptor back to software. Software points the block at the first descriptor, sets a start bit, and then only sees interrupts.

A descriptor takes four consecutive 32-bit words starting at its base address: the control word at +0, the next-descriptor pointer at +4, the buffer pointer at +8 and the status word at +12. In the control word, bit 0 is the ownership bit (1 = the block may process the descriptor), bit 1 enables following the next pointer, bit 2 enables re-polling of a next descriptor that is not yet owned, and bits 31:16 hold the frame length. A chain can be terminated, or it can be circular and ended by a descriptor the block does not own. In the circular case the block can keep re-reading that descriptor at a fixed interval until software hands it over.

Top module: `desc_chain_dma`

## Requirements
- R1: After reset, all four registers read 0, `mem_req`, `fe_start` and `irq` are 0. Register map: address 0 holds the first-descriptor pointer, address 1 bit 0 is the start bit, address 2 bits 2:0 are the interrupt enables, and address 3 bits 2:0 are the interrupt status. Status bit 0 is frame-done, bit 1 is next-not-owned and bit 2 is chain-done.
- R2: Writing 1 to bit 0 of address 1 while idle starts a walk at the pointer in address 0. The start bit reads back 1 until the block is idle again, and while idle no memory request or engine start is issued.
- R3: Descriptors are processed in chain order. Each one produces a single-cycle `fe_start` carrying buffer pointer word +8 and length bits 31:16 of word +0.
- R4: After `fe_done`, the engine status is written to word +12 and then the control word is written back with bit 0 cleared and all other bits unchanged. Status bit 0 is then set. Memory writes target only words +0 and +12.
- R5: A completed descriptor with control bit 1 = 0 sets status bits 0 and 2 together, and the block goes idle.
- R6: When control bit 1 = 1 and the next descriptor reads with bit 0 = 0, status bit 1 is set. If the current descriptor's control bit 2 is 0, status bit 2 is also set and the block goes idle.
- R7: In the case of R6 with control bit 2 = 1, the block re-reads the next descriptor's control word, with at least POLL_WAIT cycles between reads. Each read that finds bit 0 = 0 sets status bit 1. Status bit 2 is never set while polling, and processing resumes once bit 0 reads 1.
- R8: If the first descriptor of a walk reads with bit 0 = 0, only status bit 2 is set, no frame is started, and the block goes idle.
- R9: `irq` is 1 exactly when some status bit and its enable bit are both 1. Each enable acts on its own bit, and any combination may be set.
- R10: Status bits are sticky. Writing 1 to a bit at address 3 clears it, but an event that sets the same bit in the same cycle wins.
- R11: While busy, writes to the start bit and to the pointer at address 0 have no effect.
- R12: A memory request holds `mem_req`, `mem_we` and `mem_addr` stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |
| fe_start | output | 1 | Frame engine start pulse |
| fe_buf | output | 32 | Frame buffer pointer |
| fe_len | output | 16 | Frame length |
| fe_done | input | 1 | Frame engine done pulse |
| fe_status | input | 32 | Frame engine status, valid with done |

## Verification
The walk is run on five patterns:
- A three-entry terminated chain, which separates ordering and write-back faults from end-of-chain interrupt faults.
- A two-entry chain ending in an unowned descriptor without polling, which shows whether next-not-owned and chain-done fire together.
- A start on an unowned first descriptor, which must produce no frame.
- A polled chain that is handed over late, which checks poll spacing, the absence of chain-done during polling and the resumed transfer.
- A status clear timed onto a poll event, which shows whether set beats clear.

Enable-mask sweeps and writes during a busy walk separate interrupt gating from register-protection faults.

// File: rtl/desc_chain_dma.sv
module desc_chain_dma #(
  parameter int DW        = 32,
  parameter int LEN_W     = 16,
  parameter int POLL_WAIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ack,
  output logic             fe_start,
  output logic [DW-1:0]    fe_buf,
  output logic [LEN_W-1:0] fe_len,
  input  logic             fe_done,
  input  logic [DW-1:0]    fe_status
);
  localparam int CW = $clog2(POLL_WAIT + 1);
  localparam int OWN = 0, FOLLOW = 1, REPOLL = 2;

  typedef enum logic [3:0] {S_IDLE, S_RD_CTL, S_RD_NXT, S_RD_BUF, S_GO, S_XFER,
                            S_WB_ST, S_WB_CTL, S_GAP} st_t;
  st_t st;

  logic [DW-1:0] head, cur, ctl, nptr, bufp, stw;
  logic [2:0]    en, ist, ev, clr;
  logic [CW-1:0] gap;
  logic          first;

  wire busy   = st != S_IDLE;
  wire wr_go  = reg_wr && reg_addr == 2'd1 && reg_wdata[0] && !busy;
  wire ctl_ok = st == S_RD_CTL && mem_ack;
  wire owned  = mem_rdata[OWN];
  wire fin    = st == S_WB_CTL && mem_ack;

  assign ev[0] = fin;
  assign ev[1] = ctl_ok && !owned && !first;
  assign ev[2] = (fin && !ctl[FOLLOW]) || (ctl_ok && !owned && (first || !ctl[REPOLL]));
  assign clr   = (reg_wr && reg_addr == 2'd3) ? reg_wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; head <= '0; cur <= '0; ctl <= '0; nptr <= '0; bufp <= '0;
      stw <= '0; en <= '0; ist <= '0; gap <= '0; first <= 1'b0;
    end else begin
      ist <= (ist & ~clr) | ev;
      if (reg_wr && reg_addr == 2'd2) en <= reg_wdata[2:0];
      if (reg_wr && reg_addr == 2'd0 && !busy) head <= reg_wdata;
      unique case (st)
        S_IDLE: if (wr_go) begin cur <= head; first <= 1'b1; st <= S_RD_CTL; end
        S_RD_CTL: if (mem_ack) begin
          if (owned) begin ctl <= mem_rdata; first <= 1'b0; st <= S_RD_NXT; end
          else if (!first && ctl[REPOLL]) begin gap <= '0; st <= S_GAP; end
          else st <= S_IDLE;
        end
        S_RD_NXT: if (mem_ack) begin nptr <= mem_rdata; st <= S_RD_BUF; end
        S_RD_BUF: if (mem_ack) begin bufp <= mem_rdata; st <= S_GO; end
        S_GO:     st <= S_XFER;
        S_XFER:   if (fe_done) begin stw <= fe_status; st <= S_WB_ST; end
        S_WB_ST:  if (mem_ack) st <= S_WB_CTL;
        S_WB_CTL: if (mem_ack) begin
          if (ctl[FOLLOW]) begin cur <= nptr; st <= S_RD_CTL; end
          else st <= S_IDLE;
        end
        S_GAP: if (gap == CW'(POLL_WAIT - 1)) st <= S_RD_CTL; else gap <= gap + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [1:0] woff;
  always_comb begin
    unique case (st)
      S_RD_NXT: woff = 2'd1;
      S_RD_BUF: woff = 2'd2;
      S_WB_ST:  woff = 2'd3;
      default:  woff = 2'd0;
    endcase
  end

  assign mem_req   = st inside {S_RD_CTL, S_RD_NXT, S_RD_BUF, S_WB_ST, S_WB_CTL};
  assign mem_we    = st inside {S_WB_ST, S_WB_CTL};
  assign mem_addr  = cur + {{(DW-4){1'b0}}, woff, 2'b00};
  assign mem_wdata = st == S_WB_ST ? stw : (ctl & ~(DW'(1) << OWN));
  assign fe_start  = st == S_GO;
  assign fe_buf    = bufp;
  assign fe_len    = ctl[DW-1 -: LEN_W];
  assign irq       = |(ist & en);

  always_comb begin
    unique case (reg_addr)
      2'd0:    reg_rdata = head;
      2'd1:    reg_rdata = {{(DW-1){1'b0}}, busy};
      2'd2:    reg_rdata = {{(DW-3){1'b0}}, en};
      default: reg_rdata = {{(DW-3){1'b0}}, ist};
    endcase
  end
endmodule

// File: rtl/desc_chain_dma_chk.sv
module desc_chain_dma_chk #(parameter int DW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [DW-1:0] mem_addr,
  input logic          fe_start,
  input logic          busy,
  input logic [2:0]    ist,
  input logic [2:0]    clr
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R4
  wr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (mem_addr[3:2] == 2'd0 || mem_addr[3:2] == 2'd3));
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_start |=> !fe_start);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !fe_start);
  // R10
  sticky_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ist[2] && !clr[2] |=> ist[2]);
endmodule

bind desc_chain_dma desc_chain_dma_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .fe_start(fe_start), .busy(busy), .ist(ist), .clr(clr));

// File: tb/desc_chain_dma_tb_top.sv
module desc_chain_dma_tb_top;
  localparam int CLK_P = 10;
  localparam int PW = 16;

  logic clk = 0, rst_n = 0, reg_wr = 0, mem_ack = 0, fe_done = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, mem_addr, mem_wdata, mem_rdata = 0;
  logic [31:0] fe_buf, fe_status = 0;
  logic [15:0] fe_len;
  logic irq, mem_req, mem_we, fe_start;

  desc_chain_dma #(.POLL_WAIT(PW)) dut_i (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, nstarts = 0;
  logic [31:0] mem [0:255];
  logic [47:0] exp_q[$];
  logic [31:0] pollw = 32'hFFFF_FFFF;
  int polls = 0, last_poll = 0;
  int fe_cnt = 0;
  logic [31:0] fe_last = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++; $display("FAIL watchdog: actual hang expected finish");
      summary();
    end
  end

  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  always @(posedge clk) begin
    fe_done <= 1'b0;
    if (fe_start) begin fe_cnt <= 3; fe_last <= fe_buf; end
    else if (fe_cnt > 0) begin
      fe_cnt <= fe_cnt - 1;
      if (fe_cnt == 1) begin fe_done <= 1'b1; fe_status <= fe_last + 1; end
    end
  end

  always @(negedge clk) begin
    if (fe_start) begin
      nstarts++;
      if (exp_q.size() == 0) chk("R3 unexpected start", fe_buf, 32'hDEAD);
      else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        chk("R3 buffer order", fe_buf, e[31:0]);
        chk("R3 length", {16'h0, fe_len}, {16'h0, e[47:32]});
      end
    end
    if (mem_ack && !mem_we && mem_addr == pollw) begin
      polls++;
      if (polls > 1) chk("R7 poll gap", 32'(cyc - last_poll >= PW), 1);
      last_poll = cyc;
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic mk(int base, bit v, bit f, bit p, logic [15:0] len, logic [31:0] nx, logic [31:0] b);
    mem[base/4]   = {len, 13'h0, p, f, v};
    mem[base/4+1] = nx;
    mem[base/4+2] = b;
    mem[base/4+3] = 32'h0;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd1, d);
      if (d[0] == 1'b0) return;
    end
    chk("R2 idle timeout", 1, 0);
  endtask

  logic [31:0] v;
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 reg reset", v, 0); end
    chk("R1 outputs idle", {29'h0, mem_req, fe_start, irq}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // open chain of three
    mk(32'h40, 1, 1, 0, 16'd64, 32'h50, 32'h1000);
    mk(32'h50, 1, 1, 1, 16'd65, 32'h60, 32'h2000);
    mk(32'h60, 1, 0, 0, 16'd66, 32'h0,  32'h3000);
    exp_q.push_back({16'd64, 32'h1000});
    exp_q.push_back({16'd65, 32'h2000});
    exp_q.push_back({16'd66, 32'h3000});
    wr(2'd2, 7); wr(2'd0, 32'h40); wr(2'd1, 1);
    rd(2'd1, v); chk("R2 start reads busy", v, 1);
    wr(2'd0, 32'h90); wr(2'd1, 1);
    wait_idle();
    chk("R11 no restart", nstarts, 3);
    rd(2'd0, v); chk("R11 pointer kept", v, 32'h40);
    rd(2'd3, v); chk("R5 frame+chain done", v, 5);
    chk("R4 ctl A released", mem[16], {16'd64, 16'h0002});
    chk("R4 ctl B released", mem[20], {16'd65, 16'h0006});
    chk("R4 ctl C released", mem[24], {16'd66, 16'h0000});
    chk("R4 status A", mem[19], 32'h1001);
    chk("R4 status C", mem[27], 32'h3001);
    chk("R9 irq all enabled", irq, 1);

    wr(2'd2, 2); #1 chk("R9 irq masked", irq, 0);
    wr(2'd2, 4); #1 chk("R9 irq done only", irq, 1);
    wr(2'd2, 1); #1 chk("R9 irq frame only", irq, 1);
    wr(2'd3, 1); rd(2'd3, v); chk("R10 clear bit0", v, 4);
    wr(2'd3, 4); rd(2'd3, v); chk("R10 clear bit2", v, 0);
    chk("R10 irq low", irq, 0);

    // next unowned, no polling
    mk(32'h40, 1, 1, 0, 16'd10, 32'h50, 32'h4000);
    mk(32'h50, 0, 0, 0, 16'd11, 32'h0,  32'h5000);
    exp_q.push_back({16'd10, 32'h4000});
    wr(2'd2, 7); wr(2'd0, 32'h40); wr(2'd1, 1);
    wait_idle();
    rd(2'd3, v); chk("R6 next+chain done", v, 7);
    chk("R6 one frame", nstarts, 4);
    wr(2'd3, 7);

    // first unowned
    mk(32'h70, 0, 1, 1, 16'd12, 32'h40, 32'h6000);
    wr(2'd0, 32'h70); wr(2'd1, 1);
    wait_idle();
    rd(2'd3, v); chk("R8 only chain done", v, 4);
    chk("R8 no frame", nstarts, 4);
    wr(2'd3, 7);

    // polling
    mk(32'h40, 1, 1, 1, 16'd20, 32'h50, 32'h7000);
    mk(32'h50, 0, 0, 0, 16'd21, 32'h0,  32'h8000);
    pollw = 32'h50; polls = 0;
    exp_q.push_back({16'd20, 32'h7000});
    wr(2'd0, 32'h40); wr(2'd1, 1);
    for (int i = 0; i < 2000 && polls < 3; i++) @(negedge clk);
    chk("R7 repeated polls", 32'(polls >= 3), 1);
    rd(2'd3, v); chk("R7 next set, no chain done", v, 3);
    rd(2'd1, v); chk("R7 still busy", v, 1);
    begin
      int i;
      for (i = 0; i < 200; i++) begin
        @(negedge clk);
        if (mem_ack && !mem_we && mem_addr == 32'h50) break;
      end
      reg_wr = 1; reg_addr = 2'd3; reg_wdata = 32'h2;
      @(negedge clk); reg_wr = 0;
    end
    rd(2'd3, v); chk("R10 set beats clear", v, 3);
    exp_q.push_back({16'd21, 32'h8000});
    mem[20] = {16'd21, 16'h0001};
    wait_idle();
    chk("R7 resumed frame", nstarts, 6);
    rd(2'd3, v); chk("R7 resume ends with done", v & 5, 5);
    chk("R7 queue drained", exp_q.size(), 0);
    summary();
  end
endmodule